// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer with a small register interface. A 16-bit live counter counts down on a slow tick. The tick comes from the input clock through two stages: a programmable 8-bit prescaler, then a power-of-two divider chosen from four settings. Software keeps the system alive by writing a fresh value into the live counter before it runs out. If the counter expires, the block can emit a one-cycle interrupt pulse, a long reset pulse for the reset controller, or both, and the counter reloads from a separate reload register.

The register bus is a plain single-cycle port. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr` while `bus_sel` is high. The expected programming order is: write the reload and counter registers first, then set the run bit in the control word. The asynchronous active-low reset is released synchronously, two clocks after `rst_n` rises.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control word reads 0x0004 (only reset-enable set). The reload and counter registers read 0x8000. `wdt_irq` and `wdt_rst` are low.
- R2: The control word at address 0 has these fields: bit 0 run, bit 1 interrupt-enable, bit 2 reset-enable, bits 4:3 divider select, bits 15:8 prescaler value. Bits 7:5 always read 0. A write to address 0 reads back with bits 7:5 cleared.
- R3: A write to address 2 sets the live count at once, and address 2 reads the live count. Address 1 holds the reload value and reads it back. A write to address 3 has no effect, and address 3 reads 0.
- R4: While the timer runs, the counter decrements by one once every (P+1)·2^(4+S) clocks. P is the prescaler field and S is the divider select, so S = 3 gives divide-by-128.
- R5: A tick that finds the counter at 0 is an expiry, and at that edge the counter reloads from the reload register. With the prescale chain at zero and a count of N, the first expiry comes (N+1)·(P+1)·2^(4+S) clocks after the edge that sets the run bit.
- R6: On expiry, `wdt_irq` is high for exactly one clock if interrupt-enable is set. It stays low if interrupt-enable is clear.
- R7: On expiry, `wdt_rst` is high for 128 consecutive clocks if reset-enable is set. It stays low if reset-enable is clear.
- R8: While the run bit is clear, the prescale chain and the counter hold their values and no new expiry occurs.
- R9: A counter write in the same cycle as a tick takes priority over the tick. Writing the counter periodically, faster than it can run down, prevents any expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 2 | Register address: 0 control, 1 reload, 2 live count |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, zero when not selected |
| wdt_irq | output | 1 | One-clock expiry interrupt pulse |
| wdt_rst | output | 1 | 128-clock expiry reset pulse |

## Verification
Register writes are visible on the clock edge that samples them, so the bench reads them back at the next falling edge without waiting. Expiry timing is measured from the edge that sets the run bit. The bench counts rising edges with a free-running counter and expects both expiry outputs to appear exactly (N+1)·(P+1)·2^(4+S) edges later. At that same falling edge it reads the counter, which must already hold the reload value. The interrupt must be gone one edge later. The reset length is the gap between its first high sample and its first low sample, which must be 128 edges.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int BUS_W   = 16;
  localparam int PRESC_W = 8;
  localparam int DSEL_W  = 2;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_COUNT  = 2'd2
  } wdog_reg_e;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic [2:0]         rsv;
    logic [DSEL_W-1:0]  dsel;
    logic               rst_en;
    logic               irq_en;
    logic               run;
  } wdog_ctrl_t;

  localparam wdog_ctrl_t CTRL_RESET = '{presc: '0, rsv: '0, dsel: '0,
                                        rst_en: 1'b1, irq_en: 1'b0, run: 1'b0};

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter  int PRE_W       = 8,
  parameter  int SEL_W       = 2,
  parameter  int DIV_LOG_MIN = 4,
  localparam int DIV_W       = DIV_LOG_MIN + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] presc,
  input  logic [SEL_W-1:0] dsel,
  output logic             tick
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W:0]   div_span;
  logic [DIV_W-1:0] div_last;
  logic             pre_wrap, div_wrap;

  always_comb begin
    div_span = (DIV_W+1)'(1) << (DIV_LOG_MIN + int'(dsel));
    div_last = DIV_W'(div_span - 1'b1);
    pre_wrap = (pre_q == presc);
    div_wrap = (div_q == div_last);
    pre_d    = pre_q;
    div_d    = div_q;
    if (run) begin
      if (pre_wrap) begin
        pre_d = '0;
        div_d = div_wrap ? '0 : div_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
    tick = run & pre_wrap & div_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_d;
      div_q <= div_d;
    end
  end

  AST_PRESCALE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(pre_q) && $stable(div_q))); // R8

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W    = 16,
  parameter int CNT_INIT = 'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_d;
  logic             at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    expire  = tick & at_zero & ~wr_cnt;
    cnt_d   = cnt_q;
    if (wr_cnt)      cnt_d = wdata;
    else if (tick)   cnt_d = at_zero ? reload : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(CNT_INIT);
    else        cnt_q <= cnt_d;
  end

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != '0 && !wr_cnt) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == '0 && !wr_cnt) |=> (cnt_q == $past(reload))); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wdata))); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/wdog_expiry.sv
module wdog_expiry #(
  parameter  int RST_HOLD = 128,
  localparam int HOLD_W   = $clog2(RST_HOLD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic irq_en,
  input  logic rst_en,
  output logic irq_o,
  output logic rst_o
);

  logic              irq_q, irq_d;
  logic [HOLD_W-1:0] hold_q, hold_d;

  always_comb begin
    irq_d  = expire & irq_en;
    hold_d = hold_q;
    if (expire && rst_en)  hold_d = HOLD_W'(RST_HOLD);
    else if (hold_q != '0) hold_d = hold_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      irq_q  <= irq_d;
      hold_q <= hold_d;
    end
  end

  assign irq_o = irq_q;
  assign rst_o = (hold_q != '0);

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !irq_en) |=> !irq_o); // R6
  AST_RST_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |=> rst_o); // R7
  AST_RST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_o && !(expire && rst_en)) |=> !rst_o); // R7

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter  int CNT_W    = 16,
  parameter  int CNT_INIT = 'h8000,
  parameter  int RST_HOLD = 128,
  parameter  int DIV_LOG_MIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             wdt_irq,
  output logic             wdt_rst
);

  logic             rst_meta, rst_sync;
  wdog_ctrl_t       ctl_q, ctl_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_en, wr_ctl, wr_reload, wr_cnt;
  logic             tick, expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  always_comb begin
    wr_en     = bus_sel & bus_wr;
    wr_ctl    = wr_en & (bus_addr == REG_CTRL);
    wr_reload = wr_en & (bus_addr == REG_RELOAD);
    wr_cnt    = wr_en & (bus_addr == REG_COUNT);
    ctl_d     = ctl_q;
    if (wr_ctl) begin
      ctl_d     = wdog_ctrl_t'(bus_wdata);
      ctl_d.rsv = '0;
    end
    reload_d = wr_reload ? bus_wdata[CNT_W-1:0] : reload_q;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      ctl_q    <= CTRL_RESET;
      reload_q <= CNT_W'(CNT_INIT);
    end else begin
      ctl_q    <= ctl_d;
      reload_q <= reload_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        REG_CTRL:   bus_rdata = BUS_W'(ctl_q);
        REG_RELOAD: bus_rdata = BUS_W'(reload_q);
        REG_COUNT:  bus_rdata = BUS_W'(cnt_q);
        default:    bus_rdata = '0;
      endcase
    end
  end

  wdog_prescaler #(
    .PRE_W       (PRESC_W),
    .SEL_W       (DSEL_W),
    .DIV_LOG_MIN (DIV_LOG_MIN)
  ) u_prescaler (
    .clk   (clk),
    .rst_n (rst_sync),
    .run   (ctl_q.run),
    .presc (ctl_q.presc),
    .dsel  (ctl_q.dsel),
    .tick  (tick)
  );

  wdog_counter #(
    .CNT_W    (CNT_W),
    .CNT_INIT (CNT_INIT)
  ) u_counter (
    .clk    (clk),
    .rst_n  (rst_sync),
    .tick   (tick),
    .wr_cnt (wr_cnt),
    .wdata  (bus_wdata[CNT_W-1:0]),
    .reload (reload_q),
    .cnt_q  (cnt_q),
    .expire (expire)
  );

  wdog_expiry #(
    .RST_HOLD (RST_HOLD)
  ) u_expiry (
    .clk    (clk),
    .rst_n  (rst_sync),
    .expire (expire),
    .irq_en (ctl_q.irq_en),
    .rst_en (ctl_q.rst_en),
    .irq_o  (wdt_irq),
    .rst_o  (wdt_rst)
  );

  AST_STOPPED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_sync)
    !ctl_q.run |=> !wdt_irq); // R8
  AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_sync)
    tick |-> ctl_q.run); // R8

endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;

  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        wdt_irq, wdt_rst;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int irq_seen = 0;
  int rst_seen = 0;

  wdog_timer u_wdog_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wdt_irq   (wdt_irq),
    .wdt_rst   (wdt_rst)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wdt_irq) irq_seen <= irq_seen + 1;
    if (wdt_rst) rst_seen <= rst_seen + 1;
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected under 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int period(input int p, input int s);
    return (p + 1) * (16 << s);
  endfunction

  function automatic logic [15:0] ctl_word(input int p, input int s, input bit rst_en,
                                           input bit irq_en, input bit run);
    return {p[7:0], 3'b000, s[1:0], rst_en, irq_en, run};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    logic [15:0] v;
    int t_en, t_rise, t_fall, tgt, base_irq, base_rst;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    void'($urandom(32'd20240611));
    do_reset();

    // R1: reset state
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0004);
    rd(2'd1, v); chk("R1 reload", v, 16'h8000);
    rd(2'd2, v); chk("R1 count", v, 16'h8000);
    chk("R1 irq", wdt_irq, 0);
    chk("R1 rst", wdt_rst, 0);

    // R2: control layout and reserved bits
    wr(2'd0, 16'hA5FE);
    rd(2'd0, v); chk("R2 ctrl readback", v, 16'hA51E);

    // R3: reload, live count, unused address
    wr(2'd1, 16'h1234);
    rd(2'd1, v); chk("R3 reload", v, 16'h1234);
    wr(2'd2, 16'hBEEF);
    rd(2'd2, v); chk("R3 count", v, 16'hBEEF);
    wr(2'd3, 16'hFFFF);
    rd(2'd3, v); chk("R3 addr3", v, 0);
    rd(2'd2, v); chk("R3 addr3 no effect", v, 16'hBEEF);

    // R8 / R4: stop mid-run holds the count
    do_reset();
    base_irq = irq_seen; base_rst = rst_seen;
    wr(2'd2, 16'd2);
    wr(2'd0, ctl_word(0, 0, 1, 1, 1));
    repeat (20) @(negedge clk);
    wr(2'd0, ctl_word(0, 0, 1, 1, 0));
    repeat (300) @(negedge clk);
    rd(2'd2, v); chk("R8 count held after one tick (R4)", v, 1);
    chk("R8 no irq while stopped", irq_seen - base_irq, 0);
    chk("R8 no rst while stopped", rst_seen - base_rst, 0);

    // R9: keep-alive writes prevent expiry
    do_reset();
    base_irq = irq_seen; base_rst = rst_seen;
    wr(2'd2, 16'd3);
    wr(2'd0, ctl_word(0, 0, 1, 1, 1));
    for (int k = 0; k < 20; k++) begin
      repeat (29) @(negedge clk);
      wr(2'd2, 16'd3);
    end
    chk("R9 keep-alive irq", irq_seen - base_irq, 0);
    chk("R9 keep-alive rst", rst_seen - base_rst, 0);

    // R4 R5 R6 R7: random configurations plus the divide-by-128 corner
    for (int it = 0; it < 10; it++) begin
      int n, p, s, r;
      bit ie, re;
      n = $urandom_range(0, 4);
      p = $urandom_range(0, 3);
      s = (it == 0) ? 3 : $urandom_range(0, 3);
      r = $urandom_range(1, 9);
      ie = $urandom_range(0, 1);
      re = $urandom_range(0, 1);
      if (!ie && !re) ie = 1;
      do_reset();
      wr(2'd0, ctl_word(p, s, re, ie, 0));
      wr(2'd1, 16'(r));
      wr(2'd2, 16'(n));
      rd(2'd2, v); chk("R3 count loaded", v, n);
      wr(2'd0, ctl_word(p, s, re, ie, 1));
      t_en = cyc;
      tgt = (n + 1) * period(p, s);
      do @(negedge clk);
      while (!wdt_irq && !wdt_rst && (cyc - t_en) < tgt + 20);
      t_rise = cyc;
      chk("R5 expiry time", t_rise - t_en, tgt);
      chk("R6 irq follows enable", wdt_irq, ie);
      chk("R7 rst follows enable", wdt_rst, re);
      rd(2'd2, v); chk("R5 reload on expiry", v, r);
      wr(2'd0, ctl_word(p, s, re, ie, 0));
      chk("R6 irq one cycle", wdt_irq, 0);
      if (re) begin
        while (wdt_rst && (cyc - t_rise) < 400) @(negedge clk);
        t_fall = cyc;
        chk("R7 rst length", t_fall - t_rise, 128);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule